// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the bus master for a serial analog-to-digital converter with an 8-bit result. A request carries a channel number. On acceptance the block pulls chip select low and runs a serial clock derived from the system clock. It sends a start bit and the channel address, then stops driving the data line. It collects the result while the converter streams it: first a leading filler bit, then the result most significant bit first, then a repeat of the result least significant bit first.

The block compares the two copies of the result. After the last bit it raises chip select and presents the result together with a one-cycle valid pulse and an error flag. One parameter selects the pin arrangement. With separate pins, the host output is always enabled. With one wire, the host output enable is released once the address has been sent, so the converter can drive the same wire.

Top module: `sadc_host_ctrl`

## Requirements
- R1: After reset, cs_n is high, sclk is low, res_valid is low and req_ready is high. sclk stays low whenever cs_n is high.
- R2: A request is accepted in a cycle where req_valid and req_ready are both high, and cs_n then falls. Each frame has exactly CH_W+1+2*RES_W rising sclk edges (20 with the defaults), with each sclk half-period lasting HALF_PER system clocks.
- R3: While cs_n is low, the host sends a 1 start bit and then the channel number, most significant bit first. sd_out changes only in the cycle where sclk falls, and the converter samples it on rising edges.
- R4: The first bit returned after the address, which is the leading filler bit, has no effect on res_data or res_err, whatever its value.
- R5: The next RES_W bits, sampled on rising sclk edges, form res_data with the first bit received as the most significant bit.
- R6: The RES_W-1 bits that follow are result bits 1, 2, … RES_W-1, in that order. res_err is 1 exactly when any of them differs from the same bit of res_data. Bit 0 is shared by both copies and is not compared.
- R7: res_valid is high for exactly one system clock, in the same cycle in which cs_n returns high. res_data and res_err are valid in that cycle.
- R8: Once cs_n has risen, it stays high for at least two sclk periods (4*HALF_PER system clocks) before the next fall. req_ready is low from acceptance until that gap ends, and requests seen during that time have no effect.
- R9: With ONE_WIRE=1, sd_oe rises only when cs_n falls. It falls on the sclk falling edge after the last address bit, so it is high for (CH_W+1)*2*HALF_PER system clocks, and it never overlaps the time when the converter drives.
- R10: With ONE_WIRE=0, sd_oe stays high throughout operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request |
| req_chan | input | CH_W | Channel number for the request |
| req_ready | output | 1 | High when a request can be accepted |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low chip select |
| sd_out | output | 1 | Host data bit toward the converter |
| sd_oe | output | 1 | Drive enable for sd_out |
| sd_in | input | 1 | Data bit from the converter (the shared wire in one-wire mode) |
| res_valid | output | 1 | One-cycle pulse when a result is ready |
| res_data | output | RES_W | Converted result |
| res_err | output | 1 | Mismatch between the two result copies |

## Verification
Two instances run in lockstep, one with separate pins and one with a single wire, each connected to a behavioural converter. Random channels and result values check the address shifting and the capture of the most-significant-bit-first stream. Flipping single bits in the forward copy only, in the replay only, or in both shows whether the comparison skips bit 0 and flags every other bit. Setting the leading filler bit to 1, and raising requests in the middle of a frame, confirm that neither has any effect. Counting drive-enable cycles and sclk edges in each frame separates the two pin variants and pins down the frame length.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;

   // Index of the last serial-clock period of a frame
   function automatic int unsigned frame_last_period(input int unsigned ch_w,
                                                     input int unsigned res_w);
      return ch_w + 2 * res_w;
   endfunction

endpackage

// File: rtl/sadc_clk_div.sv
module sadc_clk_div #(
   parameter int unsigned HALF_PER = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int unsigned CNT_W = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
   localparam logic [CNT_W-1:0] WRAP_AT = CNT_W'(HALF_PER - 1);

   if (HALF_PER < 1) begin : g_bad_half
      $error("sadc_clk_div: HALF_PER must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap      = run && (cnt == WRAP_AT);
   assign rise_tick = wrap && !sclk;
   assign fall_tick = wrap && sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         sclk <= !sclk;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
   import sadc_pkg::*;
#(
   parameter int unsigned CH_W     = 3,
   parameter int unsigned RES_W    = 8,
   parameter int unsigned HALF_PER = 2,
   localparam int unsigned LAST_PER = frame_last_period(CH_W, RES_W),
   localparam int unsigned PER_W    = $clog2(LAST_PER + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CH_W-1:0]  req_chan,
   input  logic             fall_tick,
   output logic             req_ready,
   output logic             cs_n,
   output logic             run,
   output logic [PER_W-1:0] period,
   output logic             tx_bit,
   output logic             addr_phase,
   output logic             frame_end
);
   localparam int unsigned TX_W    = CH_W + 1;
   localparam int unsigned GAP_LEN = 4 * HALF_PER;
   localparam int unsigned GAP_W   = $clog2(GAP_LEN);
   localparam logic [PER_W-1:0] LAST_P = PER_W'(LAST_PER);
   localparam logic [PER_W-1:0] ADDR_P = PER_W'(CH_W);
   localparam logic [GAP_W-1:0] GAP_P  = GAP_W'(GAP_LEN - 1);

   seq_state_e       state;
   logic [TX_W-1:0]  tx_sr;
   logic [GAP_W-1:0] gap_cnt;

   assign req_ready  = (state == ST_IDLE);
   assign run        = (state == ST_XFER);
   assign tx_bit     = tx_sr[TX_W-1];
   assign addr_phase = run && (period <= ADDR_P);
   assign frame_end  = run && fall_tick && (period == LAST_P);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cs_n    <= 1'b1;
         period  <= '0;
         tx_sr   <= '0;
         gap_cnt <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state  <= ST_XFER;
                  cs_n   <= 1'b0;
                  period <= '0;
                  tx_sr  <= {1'b1, req_chan};
               end
            end
            ST_XFER: begin
               if (frame_end) begin
                  state   <= ST_GAP;
                  cs_n    <= 1'b1;
                  gap_cnt <= '0;
               end else if (fall_tick) begin
                  period <= period + 1'b1;
                  tx_sr  <= {tx_sr[TX_W-2:0], 1'b0};
               end
            end
            ST_GAP: begin
               if (gap_cnt == GAP_P) begin
                  state <= ST_IDLE;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sadc_rx_check.sv
module sadc_rx_check
   import sadc_pkg::*;
#(
   parameter int unsigned CH_W  = 3,
   parameter int unsigned RES_W = 8,
   localparam int unsigned LAST_PER = frame_last_period(CH_W, RES_W),
   localparam int unsigned PER_W    = $clog2(LAST_PER + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_tick,
   input  logic [PER_W-1:0] period,
   input  logic             din,
   input  logic             frame_end,
   output logic             res_valid,
   output logic [RES_W-1:0] res_data,
   output logic             res_err
);
   // Period CH_W+1 carries the leading filler bit and is skipped
   localparam logic [PER_W-1:0] FWD_LO = PER_W'(CH_W + 2);
   localparam logic [PER_W-1:0] FWD_HI = PER_W'(CH_W + 1 + RES_W);

   logic [RES_W-1:0] fwd_sr;
   logic [RES_W-1:1] rev_vec;
   logic             fwd_slot;

   assign fwd_slot = rise_tick && (period >= FWD_LO) && (period <= FWD_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_sr <= '0;
      end else if (fwd_slot) begin
         fwd_sr <= {fwd_sr[RES_W-2:0], din};
      end
   end

   // One capture flop per replayed bit, each bound to its own period
   for (genvar k = 1; k < RES_W; k++) begin : g_rev
      localparam logic [PER_W-1:0] SLOT = PER_W'(CH_W + 1 + RES_W + k);
      logic rbit;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rbit <= 1'b0;
         end else if (rise_tick && (period == SLOT)) begin
            rbit <= din;
         end
      end
      assign rev_vec[k] = rbit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_err   <= 1'b0;
      end else begin
         res_valid <= frame_end;
         if (frame_end) begin
            res_data <= fwd_sr;
            res_err  <= (rev_vec != fwd_sr[RES_W-1:1]);
         end
      end
   end

endmodule

// File: rtl/sadc_pin_ctrl.sv
module sadc_pin_ctrl #(
   parameter bit ONE_WIRE = 1'b0
) (
   input  logic tx_bit,
   input  logic addr_phase,
   output logic sd_out,
   output logic sd_oe
);
   assign sd_out = addr_phase && tx_bit;

   if (ONE_WIRE) begin : g_one_wire
      // Release the shared wire as soon as the address phase ends
      assign sd_oe = addr_phase;
   end else begin : g_two_wire
      assign sd_oe = 1'b1;
   end

endmodule

// File: rtl/sadc_host_ctrl.sv
module sadc_host_ctrl
   import sadc_pkg::*;
#(
   parameter int unsigned CH_W     = 3,
   parameter int unsigned RES_W    = 8,
   parameter int unsigned HALF_PER = 2,
   parameter bit          ONE_WIRE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CH_W-1:0]  req_chan,
   output logic             req_ready,
   output logic             sclk,
   output logic             cs_n,
   output logic             sd_out,
   output logic             sd_oe,
   input  logic             sd_in,
   output logic             res_valid,
   output logic [RES_W-1:0] res_data,
   output logic             res_err
);
   localparam int unsigned LAST_PER = frame_last_period(CH_W, RES_W);
   localparam int unsigned PER_W    = $clog2(LAST_PER + 1);

   if (CH_W < 1) begin : g_bad_ch
      $error("sadc_host_ctrl: CH_W must be at least 1");
   end
   if (RES_W < 2) begin : g_bad_res
      $error("sadc_host_ctrl: RES_W must be at least 2");
   end

   logic             run;
   logic             rise_tick;
   logic             fall_tick;
   logic [PER_W-1:0] period;
   logic             tx_bit;
   logic             addr_phase;
   logic             frame_end;

   sadc_clk_div #(
      .HALF_PER (HALF_PER)
   ) u_clk_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .sclk      (sclk),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   sadc_frame_seq #(
      .CH_W     (CH_W),
      .RES_W    (RES_W),
      .HALF_PER (HALF_PER)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_chan   (req_chan),
      .fall_tick  (fall_tick),
      .req_ready  (req_ready),
      .cs_n       (cs_n),
      .run        (run),
      .period     (period),
      .tx_bit     (tx_bit),
      .addr_phase (addr_phase),
      .frame_end  (frame_end)
   );

   sadc_rx_check #(
      .CH_W  (CH_W),
      .RES_W (RES_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_tick (rise_tick),
      .period    (period),
      .din       (sd_in),
      .frame_end (frame_end),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_err   (res_err)
   );

   sadc_pin_ctrl #(
      .ONE_WIRE (ONE_WIRE)
   ) u_pins (
      .tx_bit     (tx_bit),
      .addr_phase (addr_phase),
      .sd_out     (sd_out),
      .sd_oe      (sd_oe)
   );

endmodule

// File: rtl/sadc_host_ctrl_chk.sv
module sadc_host_ctrl_chk #(
   parameter int unsigned HALF_PER = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic sd_out,
   input logic sd_oe,
   input logic req_ready,
   input logic res_valid
);
   localparam int unsigned GAP_MIN = 4 * HALF_PER;
   localparam int unsigned HC_W    = $clog2(GAP_MIN + 1);
   localparam logic [HC_W-1:0] HC_MAX = HC_W'(GAP_MIN);

   logic [HC_W-1:0] high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         high_cnt <= HC_MAX;
      end else if (!cs_n) begin
         high_cnt <= '0;
      end else if (high_cnt != HC_MAX) begin
         high_cnt <= high_cnt + 1'b1;
      end
   end

   // R1
   idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R7
   valid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $rose(cs_n));

   // R3
   dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && !$stable(sd_out)) |-> $fell(sclk));

   // R8
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !req_ready);

   // R8
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (high_cnt >= HC_MAX));

   // R9
   oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_oe) |-> $fell(cs_n));

   // R9
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sd_oe) |-> ($fell(sclk) && !cs_n));

endmodule

bind sadc_host_ctrl sadc_host_ctrl_chk #(
   .HALF_PER (HALF_PER)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .sclk      (sclk),
   .sd_out    (sd_out),
   .sd_oe     (sd_oe),
   .req_ready (req_ready),
   .res_valid (res_valid)
);

// File: tb/sadc_host_ctrl_bench.sv
module sadc_conv_model #(
   parameter int CH_W  = 3,
   parameter int RES_W = 8
) (
   input  logic             sclk,
   input  logic             cs_n,
   input  logic             di,
   input  logic [RES_W-1:0] value,
   input  logic [RES_W-1:0] fwd_flip,
   input  logic [RES_W-1:0] rep_flip,
   input  logic             lead,
   output logic             dout,
   output logic             doe,
   output logic [CH_W:0]    got_addr,
   output int               rises
);
   int rcnt;
   int fcnt;

   initial begin
      dout = 1'b0; doe = 1'b0; got_addr = '0; rises = 0; rcnt = 0; fcnt = 0;
   end

   always @(negedge cs_n) begin
      rcnt = 0; fcnt = 0; rises = 0; got_addr = '0; doe = 1'b0;
   end

   always @(posedge cs_n) begin
      doe = 1'b0; dout = 1'b0;
   end

   always @(posedge sclk) begin
      if (!cs_n) begin
         rises = rises + 1;
         if (rcnt < CH_W + 1) got_addr = {got_addr[CH_W-1:0], di};
         rcnt = rcnt + 1;
      end
   end

   always @(negedge sclk) begin
      if (!cs_n && rcnt >= CH_W + 1) begin
         doe = 1'b1;
         if (fcnt == 0)               dout = lead;
         else if (fcnt <= RES_W)      dout = value[RES_W-fcnt] ^ fwd_flip[RES_W-fcnt];
         else if (fcnt < 2 * RES_W)   dout = value[fcnt-RES_W] ^ rep_flip[fcnt-RES_W];
         else                         dout = 1'b0;
         fcnt = fcnt + 1;
      end
   end
endmodule

module sadc_host_ctrl_bench;
   localparam int CH_W     = 3;
   localparam int RES_W    = 8;
   localparam int HALF_PER = 2;
   localparam int RISES    = CH_W + 1 + 2 * RES_W;
   localparam int OE_CYC   = (CH_W + 1) * 2 * HALF_PER;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = !clk;

   logic            req_valid = 1'b0;
   logic [CH_W-1:0] req_chan = '0;
   logic [RES_W-1:0] m_value = '0, m_fwd = '0, m_rep = '0;
   logic             m_lead = 1'b0;

   // separate-pin instance
   logic req_ready0, sclk0, cs_n0, sd_out0, sd_oe0, sd_in0, res_valid0, res_err0;
   logic [RES_W-1:0] res_data0;
   logic m0_dout, m0_doe;
   logic [CH_W:0] m0_addr;
   int m0_rises;

   // one-wire instance
   logic req_ready1, sclk1, cs_n1, sd_out1, sd_oe1, res_valid1, res_err1;
   logic [RES_W-1:0] res_data1;
   logic m1_dout, m1_doe, wire1;
   logic [CH_W:0] m1_addr;
   int m1_rises;

   assign sd_in0 = m0_doe ? m0_dout : 1'b1;
   assign wire1  = sd_oe1 ? sd_out1 : (m1_doe ? m1_dout : 1'b1);

   sadc_host_ctrl #(.CH_W(CH_W), .RES_W(RES_W), .HALF_PER(HALF_PER), .ONE_WIRE(1'b0))
   u_sadc_host_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_ready(req_ready0), .sclk(sclk0), .cs_n(cs_n0), .sd_out(sd_out0),
      .sd_oe(sd_oe0), .sd_in(sd_in0), .res_valid(res_valid0),
      .res_data(res_data0), .res_err(res_err0));

   sadc_host_ctrl #(.CH_W(CH_W), .RES_W(RES_W), .HALF_PER(HALF_PER), .ONE_WIRE(1'b1))
   u_sadc_host_ctrl_1w (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_ready(req_ready1), .sclk(sclk1), .cs_n(cs_n1), .sd_out(sd_out1),
      .sd_oe(sd_oe1), .sd_in(wire1), .res_valid(res_valid1),
      .res_data(res_data1), .res_err(res_err1));

   sadc_conv_model #(.CH_W(CH_W), .RES_W(RES_W)) u_model0 (
      .sclk(sclk0), .cs_n(cs_n0), .di(sd_out0), .value(m_value), .fwd_flip(m_fwd),
      .rep_flip(m_rep), .lead(m_lead), .dout(m0_dout), .doe(m0_doe),
      .got_addr(m0_addr), .rises(m0_rises));

   sadc_conv_model #(.CH_W(CH_W), .RES_W(RES_W)) u_model1 (
      .sclk(sclk1), .cs_n(cs_n1), .di(wire1), .value(m_value), .fwd_flip(m_fwd),
      .rep_flip(m_rep), .lead(m_lead), .dout(m1_dout), .doe(m1_doe),
      .got_addr(m1_addr), .rises(m1_rises));

   int n_checks = 0;
   int n_fails  = 0;
   bit reported = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      end
   endtask

   // Monitors sampled away from the active edge
   int oe1_cnt = 0, oe0_low = 0, clash = 0, hi_cnt = 1000, last_gap = 1000;
   logic cs_prev = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n1 && sd_oe1) oe1_cnt++;
         if (!sd_oe0) oe0_low++;
         if (sd_oe1 && m1_doe) clash++;
         if (cs_prev && !cs_n0) begin
            last_gap = hi_cnt;
            hi_cnt = 0;
         end else if (cs_n0) begin
            hi_cnt++;
         end
         cs_prev = cs_n0;
      end
   end

   function automatic logic [RES_W-1:0] exp_data(input logic [RES_W-1:0] v,
                                                  input logic [RES_W-1:0] ff);
      return v ^ ff;
   endfunction

   function automatic bit exp_err(input logic [RES_W-1:0] ff, input logic [RES_W-1:0] rf);
      logic [RES_W-1:0] d;
      d = (ff ^ rf) & ~RES_W'(1);
      return d != '0;
   endfunction

   task automatic run_txn(input logic [CH_W-1:0] ch, input logic [RES_W-1:0] v,
                          input logic [RES_W-1:0] ff, input logic [RES_W-1:0] rf,
                          input logic ld, input bit poke);
      logic [RES_W-1:0] ed;
      bit ee;
      m_value = v; m_fwd = ff; m_rep = rf; m_lead = ld;
      ed = exp_data(v, ff);
      ee = exp_err(ff, rf);
      while (!(req_ready0 && req_ready1)) @(negedge clk);
      oe1_cnt = 0; oe0_low = 0; clash = 0;
      req_valid = 1'b1; req_chan = ch;
      @(negedge clk);
      req_valid = 1'b0;
      // R8: ready drops once the request is taken
      chk(!req_ready0 && !req_ready1, "R8 ready low in frame", {req_ready0, req_ready1}, 0);
      if (poke) begin
         repeat (10) @(negedge clk);
         req_valid = 1'b1; req_chan = ~ch;
         repeat (5) @(negedge clk);
         req_valid = 1'b0;
      end
      while (!res_valid0) @(negedge clk);
      chk(res_valid1, "R7 lockstep valid", res_valid1, 1);
      chk(res_data0 == ed, "R5 data sep", res_data0, ed);
      chk(res_data1 == ed, "R5 data 1w", res_data1, ed);
      chk(res_err0 == ee, "R6 err sep", res_err0, ee);
      chk(res_err1 == ee, "R6 err 1w", res_err1, ee);
      chk(cs_n0 && cs_n1, "R7 cs high with valid", {cs_n0, cs_n1}, 3);
      chk(m0_addr == {1'b1, ch}, "R3 addr sep", m0_addr, {1'b1, ch});
      chk(m1_addr == {1'b1, ch}, "R3 addr 1w", m1_addr, {1'b1, ch});
      chk(m0_rises == RISES, "R2 sclk rises", m0_rises, RISES);
      chk(oe1_cnt == OE_CYC, "R9 oe cycles", oe1_cnt, OE_CYC);
      chk(clash == 0, "R9 no contention", clash, 0);
      chk(oe0_low == 0, "R10 oe held", oe0_low, 0);
      chk(last_gap >= 4 * HALF_PER, "R8 cs gap", last_gap, 4 * HALF_PER);
      @(negedge clk);
      chk(!res_valid0 && !res_valid1, "R7 single pulse", {res_valid0, res_valid1}, 0);
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'h5ADC));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cs_n0 && cs_n1, "R1 cs_n idle", {cs_n0, cs_n1}, 3);
      chk(!sclk0 && !sclk1, "R1 sclk idle", {sclk0, sclk1}, 0);
      chk(!res_valid0 && !res_valid1, "R1 valid idle", {res_valid0, res_valid1}, 0);
      chk(req_ready0 && req_ready1, "R1 ready idle", {req_ready0, req_ready1}, 3);

      // Directed corners
      run_txn(3'd5, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0);
      run_txn(3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);   // R4 leading 1 ignored
      run_txn(3'd7, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0);   // R4
      run_txn(3'd2, 8'h3C, 8'h01, 8'h00, 1'b0, 1'b0);   // R6 shared bit 0
      run_txn(3'd4, 8'h3C, 8'h80, 8'h00, 1'b0, 1'b0);   // R6 forward MSB flip
      run_txn(3'd1, 8'h96, 8'h00, 8'h02, 1'b0, 1'b0);   // R6 replay bit 1 flip
      run_txn(3'd6, 8'h96, 8'h40, 8'h40, 1'b0, 1'b0);   // R6 both flipped agree
      run_txn(3'd3, 8'h5A, 8'h00, 8'h00, 1'b0, 1'b1);   // R8 request during frame

      // Constrained random
      for (int i = 0; i < 30; i++) begin
         logic [CH_W-1:0] ch;
         logic [RES_W-1:0] v, ff, rf;
         ch = CH_W'($urandom);
         v  = RES_W'($urandom);
         ff = ($urandom % 4 == 0) ? RES_W'(1 << ($urandom % RES_W)) : '0;
         rf = ($urandom % 3 == 0) ? RES_W'(1 << ($urandom % RES_W)) : '0;
         run_txn(ch, v, ff, rf, 1'($urandom), ($urandom % 5 == 0));
      end

      report();
      $finish;
   end
endmodule